// File: doc/BRIEF.md
# Signed Quaternary Digit Word to Binary Converter

This block turns a word of signed base-4 digits into an ordinary two's complement integer. Each digit sits in its own 3-bit two's complement field and may hold any value from -3 to +3. Digit i carries a weight of 4 to the power i, and the block adds the weighted digits together. Because the digit set is redundant, one integer can be written as several digit strings, and the strings may mix positive and negative digits. The block returns the same integer for every one of those strings.

The converter has no clock and no storage. The integer appears at the output as soon as the input digits settle. The field pattern 100 stands for -4, which is not a legal digit. When any field holds this pattern, the block raises an error flag and forces the integer output to zero. A downstream consumer can therefore never take a half-valid number for a real result.

Top module: `qsd_to_bin`

## Requirements
- R1: For a word with no illegal field, `bin_value` read as signed equals the sum over i of d_i·4^i. Here d_i is the signed value of the field at bits [3i+2:3i] of `qsd_word`, so digit 0 is the least significant.
- R2: Each field is decoded as 3-bit two's complement: 000=0, 001=+1, 010=+2, 011=+3, 101=-3, 110=-2, 111=-1.
- R3: With N_DIGITS=8, the digits 1,0,-2,1 in positions 3 down to 0 (all higher digits zero) produce +57.
- R4: Negating every digit of a legal word negates the result. For example, -1,0,2,-1 in positions 3 down to 0 produce -57.
- R5: Different digit strings that denote the same integer give the same output. For example, 1,2 and 2,-2 in positions 1 and 0 both give 6.
- R6: The output spans the full range. All digits +3 give +(4^N-1), which is 65535 for N=8. All digits -3 give the negative of that. No legal word falls outside this range.
- R7: `bad_digit` is 1 exactly when at least one field of `qsd_word` holds the pattern 100.
- R8: While `bad_digit` is 1, `bin_value` is all zeros.
- R9: An all-zero word gives a value of 0 with `bad_digit` at 0.
- R10: For a legal word whose top digit is nonzero, the sign of the result follows that top digit, whatever the lower digits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| qsd_word | input | 3*N_DIGITS | Packed digit fields; digit i is at bits [3i+2:3i] |
| bin_value | output | 2*N_DIGITS+2 | Signed two's complement result; zero when a field is illegal |
| bad_digit | output | 1 | High when any field holds the illegal pattern 100 |

## Verification
The two functions that can act on the same input are the weighted-sum conversion and the illegal-field detection. The bench provokes both by placing the pattern 100 among otherwise legal digits: in the lowest field, in the highest field, and in every field at once. In each case it requires the flag to be high and the value to be exactly zero, and not the sum that the legal digits would give. A legal word applied straight afterwards must bring back the correct sum with the flag low. That shows the error state holds nothing over from the previous word.

// File: rtl/qsd_pkg.sv
package qsd_pkg;

    localparam int DIGIT_W = 3;

    typedef logic [DIGIT_W-1:0] qsd_field_t;

    typedef enum logic [DIGIT_W-1:0] {
        QD_ZERO  = 3'b000,
        QD_POS1  = 3'b001,
        QD_POS2  = 3'b010,
        QD_POS3  = 3'b011,
        QD_BAD   = 3'b100,
        QD_NEG3  = 3'b101,
        QD_NEG2  = 3'b110,
        QD_NEG1  = 3'b111
    } qsd_code_e;

    typedef struct packed {
        logic                      illegal;
        logic signed [DIGIT_W-1:0] digit;
    } qsd_digit_t;

    function automatic qsd_digit_t decode_field(input qsd_field_t f);
        qsd_digit_t r;
        r.illegal = (qsd_code_e'(f) == QD_BAD);
        r.digit   = $signed(f);
        return r;
    endfunction

    function automatic int out_width(input int n_digits);
        return 2 * n_digits + 2;
    endfunction

endpackage

// File: rtl/qsd_digit_term.sv
module qsd_digit_term
    import qsd_pkg::*;
#(
    parameter int POS   = 0,
    parameter int OUT_W = 18
) (
    input  logic [DIGIT_W-1:0] field,
    output logic [OUT_W-1:0]   term,
    output logic               illegal
);
    localparam int SHIFT = 2 * POS;

    qsd_digit_t dec;
    logic signed [OUT_W-1:0] ext;

    always_comb begin
        dec     = decode_field(field);
        illegal = dec.illegal;
        ext     = {{(OUT_W-DIGIT_W){dec.digit[DIGIT_W-1]}}, dec.digit};
        term    = ext <<< SHIFT;
    end
endmodule

// File: rtl/qsd_sum_tree.sv
module qsd_sum_tree #(
    parameter int N_TERMS = 8,
    parameter int OUT_W   = 18
) (
    input  logic [N_TERMS*OUT_W-1:0] terms,
    output logic [OUT_W-1:0]         total
);
    localparam int LEVELS = (N_TERMS > 1) ? $clog2(N_TERMS) : 0;
    localparam int LEAVES = 1 << LEVELS;

    logic [OUT_W-1:0] node [1:2*LEAVES-1];

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < N_TERMS) begin : g_used
            assign node[LEAVES+l] = terms[l*OUT_W +: OUT_W];
        end else begin : g_pad
            assign node[LEAVES+l] = '0;
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_add
        assign node[k] = node[2*k] + node[2*k+1];
    end

    assign total = node[1];
endmodule

// File: rtl/qsd_to_bin.sv
module qsd_to_bin
    import qsd_pkg::*;
#(
    parameter int N_DIGITS = 8
) (
    input  logic [DIGIT_W*N_DIGITS-1:0]     qsd_word,
    output logic [2*N_DIGITS+2-1:0]         bin_value,
    output logic                            bad_digit
);
    localparam int OUT_W = out_width(N_DIGITS);

    logic [N_DIGITS*OUT_W-1:0] terms;
    logic [N_DIGITS-1:0]       illegal_vec;
    logic [OUT_W-1:0]          raw_sum;

    for (genvar i = 0; i < N_DIGITS; i++) begin : g_digit
        qsd_digit_term #(
            .POS   (i),
            .OUT_W (OUT_W)
        ) term_i (
            .field   (qsd_word[i*DIGIT_W +: DIGIT_W]),
            .term    (terms[i*OUT_W +: OUT_W]),
            .illegal (illegal_vec[i])
        );
    end

    qsd_sum_tree #(
        .N_TERMS (N_DIGITS),
        .OUT_W   (OUT_W)
    ) tree_i (
        .terms (terms),
        .total (raw_sum)
    );

    always_comb begin
        bad_digit = |illegal_vec;
        bin_value = bad_digit ? '0 : raw_sum;
    end
endmodule

// File: rtl/qsd_to_bin_chk.sv
module qsd_to_bin_chk #(
    parameter int N_DIGITS = 8
) (
    input logic [3*N_DIGITS-1:0] word,
    input logic [2*N_DIGITS+1:0] value,
    input logic                  bad
);
    localparam int OW = 2 * N_DIGITS + 2;

    function automatic longint max_mag();
        longint m = 0;
        for (int i = 0; i < N_DIGITS; i++) m += longint'(3) << (2 * i);
        return m;
    endfunction

    localparam longint MAXV = max_mag();

    logic   any_bad;
    longint sval;
    logic [2:0] top;

    always_comb begin
        any_bad = 1'b0;
        for (int i = 0; i < N_DIGITS; i++)
            if (word[3*i +: 3] == 3'b100) any_bad = 1'b1;
        sval = longint'($signed(value));
        top  = word[3*N_DIGITS-1 -: 3];

        assert_flag_matches_fields_R7: assert (bad == any_bad)
            else $error("flag mismatch");
        assert_zero_on_bad_R8: assert (!bad || value == '0)
            else $error("value not zero under illegal field");
        assert_low_bits_follow_digit0_R1: assert (bad || value[1:0] == word[1:0])
            else $error("low bits disagree with digit 0");
        assert_within_range_R6: assert (bad || (sval <= MAXV && sval >= -MAXV))
            else $error("value outside representable range");
        assert_sign_follows_top_R10: assert (bad || top == 3'b000 ||
                                             (top[2] == value[OW-1] && value != '0))
            else $error("sign disagrees with top digit");
    end
endmodule

bind qsd_to_bin qsd_to_bin_chk #(.N_DIGITS(N_DIGITS)) chk_i (
    .word  (qsd_word),
    .value (bin_value),
    .bad   (bad_digit)
);

// File: tb/qsd_to_bin_tb_top.sv
`timescale 1ns/1ps
module qsd_to_bin_tb_top;
    localparam int N  = 8;
    localparam int OW = 2 * N + 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [3*N-1:0] word;
    logic [OW-1:0]  value;
    logic           bad;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    qsd_to_bin #(.N_DIGITS(N)) dut_i (
        .qsd_word  (word),
        .bin_value (value),
        .bad_digit (bad)
    );

    // d[0] is the most significant digit
    function automatic logic [3*N-1:0] pack_msb(input int d [N]);
        logic [3*N-1:0] w = '0;
        for (int k = 0; k < N; k++) w[3*(N-1-k) +: 3] = 3'(d[k]);
        return w;
    endfunction

    function automatic int ref_value(input logic [3*N-1:0] w);
        int s = 0;
        for (int i = 0; i < N; i++) begin
            int v = int'(w[3*i +: 3]);
            if (v >= 4) v = v - 8;
            s += v * (4 ** i);
        end
        return s;
    endfunction

    task automatic apply_check(input string req, input logic [3*N-1:0] w,
                               input int exp_val, input bit exp_bad);
        int got;
        @(negedge clk);
        word = w;
        #2;
        got = int'($signed(value));
        checks++;
        if (got !== exp_val || bad !== exp_bad) begin
            errors++;
            $display("FAIL %s: word=%h value=%0d bad=%0b expected value=%0d bad=%0b",
                     req, w, got, bad, exp_val, exp_bad);
        end
    endtask

    task automatic t_reset_state();
        apply_check("R9", '0, 0, 1'b0);
    endtask

    task automatic t_known_values();
        apply_check("R3", pack_msb('{0,0,0,0,1,0,-2,1}), 57, 1'b0);
        apply_check("R4", pack_msb('{0,0,0,0,-1,0,2,-1}), -57, 1'b0);
    endtask

    task automatic t_negation();
        int a [N] = '{3,-2,0,1,-3,2,-1,3};
        int b [N];
        for (int k = 0; k < N; k++) b[k] = -a[k];
        apply_check("R4", pack_msb(a), ref_value(pack_msb(a)), 1'b0);
        apply_check("R4", pack_msb(b), -ref_value(pack_msb(a)), 1'b0);
    endtask

    task automatic t_redundant();
        apply_check("R5", pack_msb('{0,0,0,0,0,0,1,2}), 6, 1'b0);
        apply_check("R5", pack_msb('{0,0,0,0,0,0,2,-2}), 6, 1'b0);
        apply_check("R5", pack_msb('{0,0,0,0,0,1,-3,-2}), 2, 1'b0);
        apply_check("R5", pack_msb('{0,0,0,0,0,0,0,2}), 2, 1'b0);
    endtask

    task automatic t_extremes();
        apply_check("R6", pack_msb('{3,3,3,3,3,3,3,3}), 65535, 1'b0);
        apply_check("R6", pack_msb('{-3,-3,-3,-3,-3,-3,-3,-3}), -65535, 1'b0);
        apply_check("R10", pack_msb('{1,-3,-3,-3,-3,-3,-3,-3}), 1, 1'b0);
        apply_check("R10", pack_msb('{-1,3,3,3,3,3,3,3}), -1, 1'b0);
    endtask

    task automatic t_digit_codes();
        int codes [7] = '{0,1,2,3,-3,-2,-1};
        for (int c = 0; c < 7; c++) begin
            logic [3*N-1:0] w0 = '0;
            logic [3*N-1:0] w3 = '0;
            w0[2:0]  = 3'(codes[c]);
            w3[11:9] = 3'(codes[c]);
            apply_check("R2", w0, codes[c], 1'b0);
            apply_check("R2", w3, codes[c] * 64, 1'b0);
        end
    endtask

    task automatic t_illegal();
        logic [3*N-1:0] w = pack_msb('{1,2,3,-1,-2,0,1,2});
        logic [3*N-1:0] wl = w;
        logic [3*N-1:0] wh = w;
        logic [3*N-1:0] wa = '0;
        wl[2:0] = 3'b100;
        wh[3*N-1 -: 3] = 3'b100;
        for (int i = 0; i < N; i++) wa[3*i +: 3] = 3'b100;
        apply_check("R7_R8", wl, 0, 1'b1);
        apply_check("R1", w, ref_value(w), 1'b0);
        apply_check("R7_R8", wh, 0, 1'b1);
        apply_check("R7_R8", wa, 0, 1'b1);
        apply_check("R9", '0, 0, 1'b0);
    endtask

    task automatic t_sweep();
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 300; n++) begin
            logic [3*N-1:0] w;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            w = lfsr[3*N-1:0] ^ {lfsr[7:0], lfsr[31:16]};
            for (int i = 0; i < N; i++)
                if (w[3*i +: 3] == 3'b100) w[3*i +: 3] = 3'b000;
            apply_check("R1", w, ref_value(w), 1'b0);
        end
    endtask

    initial begin
        word = '0;
        repeat (2) @(posedge clk);
        t_reset_state();
        t_known_values();
        t_negation();
        t_redundant();
        t_extremes();
        t_digit_codes();
        t_illegal();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule